// File: doc/BRIEF.md
# Length-Prefixed Serial Packet Receiver

This block sits behind a byte source such as a UART receiver and turns the raw byte stream into framed packets. A frame opens with a header byte whose most significant bit is set; the remaining seven bits select a command. Next comes a length byte, and then exactly that many payload bytes. The block writes the payload bytes into a small local buffer. When the frame is complete, it raises a one-cycle completion strobe and presents the command index and the frame length.

A downstream dispatcher waits for the strobe. It then reads the payload through an asynchronous read port, addressed from zero. The block drops malformed input without any indication: stray bytes between frames, headers whose command index is not supported, and lengths larger than the buffer. After such input the block returns to hunting for the next header. A zero-length frame completes straight after its length byte.

Top module: `pkt_rx`

## Requirements
- R1: After reset, `done` is 0, `cmd_idx` is 0 and `pkt_len` is 0.
- R2: While waiting for a header, a byte with bit 7 equal to 0 is discarded. It produces no strobe, leaves `cmd_idx` unchanged, and the next byte is still treated as a header candidate.
- R3: A byte with bit 7 set whose low seven bits are at or above `NUM_CMDS` (default 10) is discarded as a header. The block keeps waiting for a header.
- R4: A byte with bit 7 set and low seven bits below `NUM_CMDS` is accepted as a header. `cmd_idx` takes the low seven bits one cycle later, and the following valid byte is taken as the length.
- R5: A length byte greater than `MAX_LEN` (default 16) abandons the frame. No strobe follows, `pkt_len` keeps its previous value, and the next byte is treated as a header candidate.
- R6: A length byte of 0 completes the frame. `done` is 1 in the cycle after that byte is accepted, and `pkt_len` reads 0.
- R7: For a length N from 1 to `MAX_LEN`, the N payload bytes are stored at buffer addresses 0 to N-1 in arrival order. Payload values are unrestricted, so bytes with bit 7 set are stored as data. `done` rises in the cycle after the Nth byte is accepted, and `pkt_len` reads N.
- R8: `done` is high for exactly one cycle per completed frame. `cmd_idx`, `pkt_len` and the buffer contents hold until a later header and length replace them.
- R9: A cycle with `in_valid` low changes nothing, whatever value `in_byte` carries.
- R10: After a frame completes, the block is waiting for a header again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | `in_byte` holds a received byte this cycle |
| in_byte | input | 8 | Received byte |
| done | output | 1 | One-cycle strobe marking a complete frame |
| cmd_idx | output | 7 | Command index of the last accepted header |
| pkt_len | output | $clog2(MAX_LEN+1) | Length of the last accepted length byte |
| rd_addr | input | $clog2(MAX_LEN) | Payload buffer read address |
| rd_data | output | 8 | Payload byte at `rd_addr`, combinational |

## Verification
A wrong parser state shows up at the ports within the frame in which it occurs. If the block believes it is still waiting for a header when it is not, a zero-length frame fails to strobe. If it believes it is inside a frame when it is not, a strobe arrives one byte early or late. The header sweep sends every byte value, each followed by a zero byte, so a misclassified header appears on the very next byte as a missing or extra `done`. Payload ordering and pointer errors surface as soon as the buffer is read back after the strobe. The same readback also exposes a count that is off by one against `pkt_len`.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_LEN  = 2'd1,
        ST_BODY = 2'd2
    } rx_state_e;
endpackage

// File: rtl/pkt_rx_buf.sv
module pkt_rx_buf #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 8,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [AW-1:0]     raddr,
    output logic [DATA_W-1:0] rdata
);
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    assign rdata = mem_q[raddr];
endmodule

// File: rtl/pkt_rx_fsm.sv
module pkt_rx_fsm
    import pkt_rx_pkg::*;
#(
    parameter int NUM_CMDS = 10,
    parameter int MAX_LEN  = 16,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int PTR_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             done,
    output logic [6:0]       cmd_idx,
    output logic [LEN_W-1:0] pkt_len,
    output logic             wr_en,
    output logic [PTR_W-1:0] wr_addr,
    output logic [7:0]       wr_data
);
    localparam logic [7:0] NUM_CMDS_B = 8'(NUM_CMDS);
    localparam logic [7:0] MAX_LEN_B  = 8'(MAX_LEN);

    typedef struct packed {
        rx_state_e        st;
        logic [6:0]       cmd;
        logic [LEN_W-1:0] len;
        logic [LEN_W-1:0] rem;
        logic [PTR_W-1:0] ptr;
        logic             done;
    } fsm_t;

    fsm_t q_q, q_d;
    logic hdr_ok;

    assign hdr_ok = in_byte[7] && ({1'b0, in_byte[6:0]} < NUM_CMDS_B);

    always_comb begin
        q_d      = q_q;
        q_d.done = 1'b0;
        wr_en    = 1'b0;
        case (q_q.st)
            ST_HUNT: begin
                if (in_valid && hdr_ok) begin
                    q_d.cmd = in_byte[6:0];
                    q_d.ptr = '0;
                    q_d.st  = ST_LEN;
                end
            end
            ST_LEN: begin
                if (in_valid) begin
                    if (in_byte > MAX_LEN_B) begin
                        q_d.st = ST_HUNT;
                    end else begin
                        q_d.len = in_byte[LEN_W-1:0];
                        q_d.rem = in_byte[LEN_W-1:0];
                        if (in_byte == 8'd0) begin
                            q_d.done = 1'b1;
                            q_d.st   = ST_HUNT;
                        end else begin
                            q_d.st = ST_BODY;
                        end
                    end
                end
            end
            ST_BODY: begin
                if (in_valid) begin
                    wr_en   = 1'b1;
                    q_d.ptr = q_q.ptr + PTR_W'(1);
                    q_d.rem = q_q.rem - LEN_W'(1);
                    if (q_q.rem == LEN_W'(1)) begin
                        q_d.done = 1'b1;
                        q_d.st   = ST_HUNT;
                    end
                end
            end
            default: q_d.st = ST_HUNT;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q_q <= '{st: ST_HUNT, cmd: '0, len: '0, rem: '0, ptr: '0, done: 1'b0};
        end else begin
            q_q <= q_d;
        end
    end

    assign done    = q_q.done;
    assign cmd_idx = q_q.cmd;
    assign pkt_len = q_q.len;
    assign wr_addr = q_q.ptr;
    assign wr_data = in_byte;

    // R2
    stray_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_q.st == ST_HUNT && !in_byte[7]) |=> (q_q.st == ST_HUNT && !done));

    // R4
    header_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_q.st == ST_HUNT && hdr_ok) |=> (q_q.st == ST_LEN && cmd_idx == $past(in_byte[6:0])));

    // R5
    oversize_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_q.st == ST_LEN && in_byte > MAX_LEN_B) |=> (q_q.st == ST_HUNT && !done && $stable(pkt_len)));

    // R6
    zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && q_q.st == ST_LEN && in_byte == 8'd0) |=> (done && q_q.st == ST_HUNT));

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R9
    idle_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!done && $stable(q_q.st) && $stable(cmd_idx) && $stable(pkt_len)));
endmodule

// File: rtl/pkt_rx.sv
module pkt_rx #(
    parameter int NUM_CMDS = 10,
    parameter int MAX_LEN  = 16,
    localparam int LEN_W   = $clog2(MAX_LEN + 1),
    localparam int PTR_W   = $clog2(MAX_LEN)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [7:0]       in_byte,
    output logic             done,
    output logic [6:0]       cmd_idx,
    output logic [LEN_W-1:0] pkt_len,
    input  logic [PTR_W-1:0] rd_addr,
    output logic [7:0]       rd_data
);
    logic             wr_en;
    logic [PTR_W-1:0] wr_addr;
    logic [7:0]       wr_data;

    pkt_rx_fsm #(.NUM_CMDS(NUM_CMDS), .MAX_LEN(MAX_LEN)) u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_valid(in_valid),
        .in_byte (in_byte),
        .done    (done),
        .cmd_idx (cmd_idx),
        .pkt_len (pkt_len),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data)
    );

    pkt_rx_buf #(.DEPTH(MAX_LEN), .DATA_W(8)) u_buf (
        .clk  (clk),
        .we   (wr_en),
        .waddr(wr_addr),
        .wdata(wr_data),
        .raddr(rd_addr),
        .rdata(rd_data)
    );
endmodule

// File: tb/pkt_rx_test.sv
`timescale 1ns/1ps
module pkt_rx_test;
    localparam int NC = 10;
    localparam int ML = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_byte = 8'h00;
    logic       done;
    logic [6:0] cmd_idx;
    logic [4:0] pkt_len;
    logic [3:0] rd_addr = 4'd0;
    logic [7:0] rd_data;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pkt_rx #(.NUM_CMDS(NC), .MAX_LEN(ML)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
        .done(done), .cmd_idx(cmd_idx), .pkt_len(pkt_len),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // one accepted byte; on return the registered outputs reflect it
    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_byte  = b;
        @(negedge clk);
        in_valid = 1'b0;
        in_byte  = ~b;
    endtask

    task automatic gap(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_byte = 8'(i * 37 + 129);
        end
    endtask

    function automatic logic [7:0] pat(input int l, input int i);
        return 8'((l * 7 + i * 13) ^ 8'hA5);
    endfunction

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int last_len;
        repeat (3) @(negedge clk);
        // R1
        chk(done == 1'b0, "R1 done", int'(done), 0);
        chk(cmd_idx == 7'd0, "R1 cmd", int'(cmd_idx), 0);
        chk(pkt_len == 5'd0, "R1 len", int'(pkt_len), 0);
        rst_n = 1'b1;
        gap(2);

        // R2 R3 R4 R6 R10: every byte as a header candidate, then a zero byte
        for (int b = 0; b < 256; b++) begin
            bit valid_hdr;
            int prev_cmd;
            valid_hdr = (b >= 128) && ((b - 128) < NC);
            prev_cmd  = int'(cmd_idx);
            send(8'(b));
            chk(done == 1'b0, "R2/R3 no strobe on header byte", int'(done), 0);
            if (valid_hdr) chk(int'(cmd_idx) == b - 128, "R4 cmd_idx", int'(cmd_idx), b - 128);
            else           chk(int'(cmd_idx) == prev_cmd, "R3 cmd_idx kept", int'(cmd_idx), prev_cmd);
            send(8'h00);
            chk(int'(done) == int'(valid_hdr), "R6 zero length strobe", int'(done), int'(valid_hdr));
            if (valid_hdr) chk(pkt_len == 5'd0, "R6 pkt_len", int'(pkt_len), 0);
            gap(1);
            chk(done == 1'b0, "R8 strobe width", int'(done), 0);
        end

        // R7 R8 R9 R5: length sweep
        last_len = 0;
        for (int l = 1; l <= ML + 4; l++) begin
            send(8'h83);
            send(8'(l));
            if (l > ML) begin
                chk(done == 1'b0, "R5 no strobe", int'(done), 0);
                chk(int'(pkt_len) == last_len, "R5 pkt_len kept", int'(pkt_len), last_len);
                send(8'h00);
                chk(done == 1'b0, "R5 back to hunting", int'(done), 0);
                send(8'h81);
                send(8'h00);
                chk(done == 1'b1 && cmd_idx == 7'd1, "R5 next frame accepted", int'(cmd_idx), 1);
                last_len = 0;
            end else begin
                for (int i = 0; i < l; i++) begin
                    send(pat(l, i));
                    if (i % 3 == 1) gap(2); // R9 idle cycles with changing data
                    if (i < l - 1) chk(done == 1'b0, "R7 early strobe", int'(done), 0);
                end
                if (l % 3 != 2 || l == 1) begin
                    chk(done == 1'b1, "R7 strobe after last byte", int'(done), 1);
                end
                chk(int'(pkt_len) == l, "R7 pkt_len", int'(pkt_len), l);
                chk(cmd_idx == 7'd3, "R8 cmd held", int'(cmd_idx), 3);
                gap(3);
                chk(done == 1'b0, "R8 single strobe", int'(done), 0);
                send(8'h11); // R10 stray byte after frame: ignored
                chk(done == 1'b0 && int'(pkt_len) == l, "R10 stray after frame", int'(pkt_len), l);
                for (int i = 0; i < l; i++) begin
                    rd_addr = 4'(i);
                    #1;
                    chk(rd_data == pat(l, i), "R7 payload", int'(rd_data), int'(pat(l, i)));
                end
                last_len = l;
            end
        end

        // R9: a header offered only with in_valid low is not taken
        @(negedge clk);
        in_byte = 8'h82;
        gap(1);
        send(8'h00);
        chk(done == 1'b0, "R9 invalid cycle ignored", int'(done), 0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end
endmodule